// File: doc/BRIEF.md
# Dual-Carrier Three-Phase PWM Generator

This block produces the three upper-switch commands for a two-level three-phase inverter. It compares three signed references against a triangle carrier. In dual-carrier mode, each phase can instead compare against the negated copy of that carrier. Each phase chooses between the two from its own fundamental angle, measured relative to a programmable carrier start angle. Because the phases use opposite carriers over suitable parts of the cycle, the all-low and all-high switch patterns are suppressed. These patterns are the ones that drive the common-mode voltage to its peak.

The fundamental angle comes in as a 16-bit phase accumulator in which a full wrap is one electrical revolution. The other two phase angles are derived from it with a fixed one-third-turn offset. A carrier choice only changes when the carrier is at its peak or its valley, so no pulse is ever cut by a carrier swap. With dual mode off, the block behaves as a plain single-carrier sine-triangle modulator. A registered flag marks every clock cycle in which the three commands are all equal.

Top module: `dual_carrier_pwm`

## Requirements
- R1: After reset the base carrier starts at -PEAK and rises. It moves by exactly one step per clock, turns at +PEAK and at -PEAK, and repeats every 4*PEAK clocks.
- R2: Each command is registered. It is 1 on the clock after the one in which its reference was strictly greater than the carrier that the phase was using, and 0 otherwise.
- R3: With dual mode off, every phase uses the base carrier.
- R4: With dual mode on, each phase's angle is formed first: phase a is the accumulator, phase b is the accumulator minus 21845, and phase c is the accumulator plus 21845, all modulo 2^16. The carrier start angle is then subtracted, modulo 2^16. If the result is below 32768 the phase uses the base carrier; otherwise it uses the negated carrier. At any latch point no more than two phases share a carrier.
- R5: The carrier start angle is clamped to the range 10923 to 21845 before use. A lower value acts as 10923 and a higher value acts as 21845.
- R6: Carrier choices, and the mode that governs them, are sampled only in a cycle where the base carrier sits at +PEAK or -PEAK. In all other cycles they hold.
- R7: The zero-vector flag is 1 exactly when the three registered commands are all 0 or all 1.
- R8: While reset is asserted, all commands and the flag are 0. Operation resumes on the third rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dual_en | input | 1 | 1 selects dual-carrier mode, 0 selects single carrier |
| phase_acc | input | ANG_W | Fundamental angle of phase a, 2^ANG_W is one turn |
| theta1 | input | ANG_W | Carrier start angle, same encoding, clamped |
| ref_a | input | REF_W | Signed reference of phase a, full scale ±PEAK |
| ref_b | input | REF_W | Signed reference of phase b |
| ref_c | input | REF_W | Signed reference of phase c |
| sw_a | output | 1 | Upper-switch command of phase a |
| sw_b | output | 1 | Upper-switch command of phase b |
| sw_c | output | 1 | Upper-switch command of phase c |
| zero_vec | output | 1 | Commands all equal in this cycle |

## Verification
Some properties are checked on every cycle. The carrier must stay in range, step by one and never sit at an extreme twice in a row. Carrier choices must be frozen between extremes, must all be the base carrier when dual mode is off, and must always be mixed when it is on. The clamped start angle must stay inside its window, and the flag must agree with the commands. Other behaviour only the bench's scenarios can show. This includes the exact angle thresholds, which values the clamp produces, when a mid-period mode toggle takes effect, and the pulse pattern under fixed and swept sinusoidal references. The bench model predicts all of these cycle by cycle.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
  localparam int NPH = 3;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic {
    CAR_BASE = 1'b0,
    CAR_INV  = 1'b1
  } car_e;
endpackage

// File: rtl/dcpwm_carrier.sv
module dcpwm_carrier
  import dcpwm_pkg::*;
#(
  parameter int PEAK  = 16,
  parameter int CAR_W = $clog2(PEAK) + 2
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  output logic signed [CAR_W-1:0] car_o,
  output logic                    ext_o
);
  localparam logic signed [CAR_W-1:0] TOP = CAR_W'(PEAK);
  localparam logic signed [CAR_W-1:0] BOT = CAR_W'(-PEAK);
  localparam logic signed [CAR_W-1:0] ONE = CAR_W'(1);

  logic signed [CAR_W-1:0] car_q, car_d;
  dir_e                    dir_q, dir_d;

  // next state: count toward the current extreme, turn on arrival
  always_comb begin
    car_d = car_q;
    dir_d = dir_q;
    if (dir_q == DIR_UP) begin
      car_d = car_q + ONE;
      if (car_q == TOP - ONE) dir_d = DIR_DOWN;
    end else begin
      car_d = car_q - ONE;
      if (car_q == BOT + ONE) dir_d = DIR_UP;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= BOT;
      dir_q <= DIR_UP;
    end else begin
      car_q <= car_d;
      dir_q <= dir_d;
    end
  end

  assign car_o = car_q;
  assign ext_o = (car_q == TOP) || (car_q == BOT);
endmodule

// File: rtl/dcpwm_select.sv
module dcpwm_select
  import dcpwm_pkg::*;
#(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dual_en_i,
  input  logic [ANG_W-1:0] acc_i,
  input  logic [ANG_W-1:0] th_i,
  output logic [NPH-1:0]   sel_o
);
  localparam int FULL  = 1 << ANG_W;
  localparam int THIRD = FULL / 3;

  logic [NPH-1:0] sel_d, sel_q;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    localparam int OFFI = (g == 0) ? 0 : ((g == 1) ? (FULL - THIRD) : THIRD);
    logic [ANG_W-1:0] ang;
    logic [ANG_W-1:0] rel;
    assign ang      = acc_i + ANG_W'(OFFI);
    assign rel      = ang - th_i;
    // upper half of the relative turn -> inverted carrier
    assign sel_d[g] = dual_en_i & rel[ANG_W-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (load_i) begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/dcpwm_compare.sv
module dcpwm_compare
  import dcpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CAR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic signed [CAR_W-1:0] car_i,
  input  logic                    inv_i,
  output logic                    sw_d_o,
  output logic                    sw_o
);
  logic signed [CAR_W-1:0] car_sel;
  logic signed [REF_W-1:0] car_x;
  logic                    sw_q;

  always_comb begin
    car_sel = (car_e'(inv_i) == CAR_INV) ? -car_i : car_i;
    car_x   = REF_W'(car_sel);
    sw_d_o  = ref_i > car_x;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sw_q <= 1'b0;
    else         sw_q <= sw_d_o;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/dual_carrier_pwm.sv
module dual_carrier_pwm
  import dcpwm_pkg::*;
#(
  parameter int PEAK  = 16,
  parameter int REF_W = 12,
  parameter int ANG_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dual_en,
  input  logic [ANG_W-1:0]        phase_acc,
  input  logic [ANG_W-1:0]        theta1,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  output logic                    sw_a,
  output logic                    sw_b,
  output logic                    sw_c,
  output logic                    zero_vec
);
  localparam int CAR_W = $clog2(PEAK) + 2;
  localparam int FULL  = 1 << ANG_W;
  localparam int THIRD = FULL / 3;
  localparam logic [ANG_W-1:0] TH_LO = ANG_W'((THIRD + 1) / 2);
  localparam logic [ANG_W-1:0] TH_HI = ANG_W'(THIRD);

  // reset: asserted at once, removed after two clock edges
  logic rst_m, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m    <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_m    <= 1'b1;
      rst_sync <= rst_m;
    end
  end

  logic signed [CAR_W-1:0] car;
  logic                    car_ext;

  dcpwm_carrier #(.PEAK(PEAK), .CAR_W(CAR_W)) u_car (
    .clk    (clk),
    .rst_ni (rst_sync),
    .car_o  (car),
    .ext_o  (car_ext)
  );

  logic [ANG_W-1:0] th_eff;
  always_comb begin
    if (theta1 < TH_LO)      th_eff = TH_LO;
    else if (theta1 > TH_HI) th_eff = TH_HI;
    else                     th_eff = theta1;
  end

  logic [NPH-1:0] sel_q;

  dcpwm_select #(.ANG_W(ANG_W)) u_sel (
    .clk       (clk),
    .rst_ni    (rst_sync),
    .load_i    (car_ext),
    .dual_en_i (dual_en),
    .acc_i     (phase_acc),
    .th_i      (th_eff),
    .sel_o     (sel_q)
  );

  logic signed [REF_W-1:0] ref_v [NPH];
  logic [NPH-1:0]          sw_d, sw_q;

  assign ref_v[0] = ref_a;
  assign ref_v[1] = ref_b;
  assign ref_v[2] = ref_c;

  for (genvar g = 0; g < NPH; g++) begin : g_cmp
    dcpwm_compare #(.REF_W(REF_W), .CAR_W(CAR_W)) u_cmp (
      .clk    (clk),
      .rst_ni (rst_sync),
      .ref_i  (ref_v[g]),
      .car_i  (car),
      .inv_i  (sel_q[g]),
      .sw_d_o (sw_d[g]),
      .sw_o   (sw_q[g])
    );
  end

  logic zv_d, zv_q;
  assign zv_d = (&sw_d) | ~(|sw_d);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) zv_q <= 1'b0;
    else           zv_q <= zv_d;
  end

  assign sw_a     = sw_q[0];
  assign sw_b     = sw_q[1];
  assign sw_c     = sw_q[2];
  assign zero_vec = zv_q;
endmodule

// File: rtl/dcpwm_chk.sv
module dcpwm_chk #(
  parameter int PEAK  = 16,
  parameter int ANG_W = 16,
  parameter int CAR_W = 6
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic signed [CAR_W-1:0] car,
  input logic                    ext,
  input logic [2:0]              sel,
  input logic [2:0]              sw,
  input logic                    zv,
  input logic                    dual_en,
  input logic [ANG_W-1:0]        th_eff
);
  localparam int THIRD = (1 << ANG_W) / 3;
  localparam int LO    = (THIRD + 1) / 2;

  p_car_range_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (int'(car) >= -PEAK) && (int'(car) <= PEAK));

  p_car_step_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((int'(car) - int'($past(car)) == 1) || (int'(car) - int'($past(car)) == -1)));

  p_car_turn_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    ext |=> !ext);

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !ext |=> $stable(sel));

  p_conv_mode_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext && !dual_en) |=> (sel == 3'b000));

  p_dual_mixed_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext && dual_en) |=> ((sel != 3'b000) && (sel != 3'b111)));

  p_theta_clamp_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (int'(th_eff) >= LO) && (int'(th_eff) <= THIRD));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (zv == ((sw == 3'b000) || (sw == 3'b111))));
endmodule

bind dual_carrier_pwm dcpwm_chk #(.PEAK(PEAK), .ANG_W(ANG_W), .CAR_W(CAR_W)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync),
  .car     (car),
  .ext     (car_ext),
  .sel     (sel_q),
  .sw      (sw_q),
  .zv      (zero_vec),
  .dual_en (dual_en),
  .th_eff  (th_eff)
);

// File: tb/dual_carrier_pwm_tb_top.sv
module dual_carrier_pwm_tb_top;
  localparam int PEAK  = 16;
  localparam int REF_W = 12;
  localparam int ANG_W = 16;
  localparam int FULL  = 65536;
  localparam int THIRD = 21845;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst_n = 1'b0;
  logic                    dual_en = 1'b0;
  logic [ANG_W-1:0]        acc = '0;
  logic [ANG_W-1:0]        th1 = 16'd16384;
  logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
  logic                    sa, sb, sc, zv;

  dual_carrier_pwm #(.PEAK(PEAK), .REF_W(REF_W), .ANG_W(ANG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .phase_acc(acc), .theta1(th1),
    .ref_a(ra), .ref_b(rb), .ref_c(rc),
    .sw_a(sa), .sw_b(sb), .sw_c(sc), .zero_vec(zv)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    chk_on = 1'b0;
  bit    sine_mode = 1'b0;
  string cur_tag = "R8";

  // behavioural reference model
  int       mc = -PEAK;
  bit       mup = 1'b1;
  int       mrel = 0;
  bit [2:0] msel = '0;
  bit [2:0] ms = '0;
  bit       mzv = 1'b0;

  function automatic int clamp_th(int t);
    if (t < 10923) return 10923;
    if (t > 21845) return 21845;
    return t;
  endfunction

  function automatic int sine_ref(int ang);
    real x;
    x = 0.8 * PEAK * $sin(2.0 * 3.14159265358979 * ang / 65536.0);
    return $rtoi(x);
  endfunction

  always @(posedge clk) begin : model
    int r;
    int car;
    int refs [3];
    int offs [3];
    bit [2:0] nsel;
    bit [2:0] ns;
    r = mrel;
    if (!rst_n) mrel = 0;
    else if (mrel < 2) mrel++;
    if (!rst_n || r < 2) begin
      mc = -PEAK; mup = 1'b1; msel = '0; ms = '0; mzv = 1'b0;
    end else begin
      refs[0] = int'(ra); refs[1] = int'(rb); refs[2] = int'(rc);
      offs[0] = 0; offs[1] = FULL - THIRD; offs[2] = THIRD;
      for (int i = 0; i < 3; i++) begin
        car   = msel[i] ? -mc : mc;
        ns[i] = refs[i] > car;
      end
      nsel = msel;
      if (mc == PEAK || mc == -PEAK) begin
        for (int i = 0; i < 3; i++) begin
          int ang;
          int rel;
          ang     = (int'(acc) + offs[i]) % FULL;
          rel     = (ang - clamp_th(int'(th1)) + FULL) % FULL;
          nsel[i] = dual_en && (rel >= FULL / 2);
        end
      end
      if (mup) begin mc++; if (mc == PEAK) mup = 1'b0; end
      else     begin mc--; if (mc == -PEAK) mup = 1'b1; end
      msel = nsel;
      ms   = ns;
      mzv  = (ns == 3'b000) || (ns == 3'b111);
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      checks += 2;
      if (!rst_n) begin
        if ({sc, sb, sa} != 3'b000) begin
          fails++;
          $display("FAIL R8 sw actual %b expected 000", {sc, sb, sa});
        end
        if (zv != 1'b0) begin
          fails++;
          $display("FAIL R8 zero_vec actual %b expected 0", zv);
        end
      end else begin
        if ({sc, sb, sa} != ms) begin
          fails++;
          $display("FAIL %s sw actual %b expected %b (t=%0t)", cur_tag, {sc, sb, sa}, ms, $time);
        end
        if (zv != mzv) begin
          fails++;
          $display("FAIL R7 zero_vec actual %b expected %b (t=%0t)", zv, mzv, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R1 actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run(int n, int step);
    repeat (n) begin
      @(posedge clk);
      #2;
      acc = acc + ANG_W'(step);
      if (sine_mode) begin
        ra = REF_W'(sine_ref(int'(acc)));
        rb = REF_W'(sine_ref((int'(acc) - THIRD + FULL) % FULL));
        rc = REF_W'(sine_ref((int'(acc) + THIRD) % FULL));
      end
    end
  endtask

  initial begin
    // R8: reset state
    @(posedge clk); #2;
    chk_on = 1'b1;
    run(5, 0);
    rst_n = 1'b1;

    // R1 R2 R3: fixed references, single carrier
    cur_tag = "R1 R2 R3";
    ra = 12'sd5; rb = -12'sd3; rc = 12'sd0;
    run(200, 0);
    ra = 12'sd16; rb = -12'sd16; rc = 12'sd15;
    run(70, 0);

    // R3 R7: swept sine, single carrier
    cur_tag = "R3 R7";
    sine_mode = 1'b1;
    run(1024, 64);

    // R4 R6: dual carrier at the default start angle
    cur_tag = "R4 R6";
    dual_en = 1'b1; th1 = 16'd16384;
    run(1100, 64);
    th1 = 16'd11000;
    run(1024, 64);

    // R5: out-of-range start angles
    cur_tag = "R5 low";
    th1 = 16'd0;
    run(1024, 64);
    cur_tag = "R5 high";
    th1 = 16'd60000;
    run(1024, 64);

    // R6: mode toggles off the carrier extremes
    cur_tag = "R6 toggle";
    th1 = 16'd16384;
    for (int k = 0; k < 40; k++) begin
      dual_en = ~dual_en;
      run(13, 96);
    end

    // R8: reset in mid run, then recovery
    cur_tag = "R8 rerun";
    @(posedge clk); #2;
    rst_n = 1'b0;
    run(4, 64);
    rst_n = 1'b1;
    dual_en = 1'b1;
    run(300, 64);

    @(negedge clk);
    chk_on = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule